// File: doc/BRIEF.md
# Program Counter and Return Stack

This block keeps the fetch address of a processor core whose program memory is byte-addressed and 16 bits wide. Instructions always start at even byte addresses, so the counter moves in steps of two bytes. Each cycle, an operation code from the decoder picks how the next fetch address is formed. It can step to the next instruction, move by a signed number of instructions, load an absolute word target, call, return, or load the counter from a software byte write. In that last case the written byte fills the low eight address bits, and two externally held latch values fill the upper bits in the same cycle.

A call saves the address of the instruction after the call in a 31-entry hardware stack. A return loads the newest saved address back into the counter. The stack depth is visible on a pointer output. Two sticky flags record a call made when the stack was full and a return made when it was empty. Every operation takes effect at the clock edge that samples it. The outputs show the result from the next cycle on.

Top module: `prog_ctr_stack`

## Requirements
- R1: After reset the fetch address, stack pointer, overflow flag and underflow flag all read 0.
- R2: Operation code 1 (advance) adds 2 to the fetch address, wrapping modulo 2^21. Bit 0 of the fetch address is 0 after every operation.
- R3: Operation code 2 (relative) adds twice the signed 12-bit two's-complement instruction count `rel_i` to the fetch address, modulo 2^21. A count of 4 therefore adds 8.
- R4: Operation code 3 (jump) loads the fetch address with the 20-bit word target `tgt_i` shifted left by one bit.
- R5: Operation code 4 (call) with fewer than 31 saved entries saves the current fetch address plus 2, increments the stack pointer, and loads the fetch address as a jump does.
- R6: Operation code 5 (return) with at least one saved entry loads the most recently saved address and decrements the stack pointer. Nested calls return in last-in first-out order.
- R7: Operation code 6 (low write) loads the fetch address with `up_latch_i` in bits 20..16, `hi_latch_i` in bits 15..8 and `lo_i` in bits 7..1. Bit 0 of `lo_i` is discarded.
- R8: Operation codes 0 and 7 leave the fetch address, the stack pointer and both flags unchanged.
- R9: A call while 31 entries are saved sets the overflow flag and still loads the target. It leaves the stack pointer at 31 and the saved entries unchanged. The flag stays set until reset.
- R10: A return while the stack is empty sets the underflow flag and loads a fetch address of 0. The stack pointer stays 0. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 3 | Operation code for this cycle |
| rel_i | input | 12 | Signed instruction count for relative moves |
| tgt_i | input | 20 | Word target for jump and call |
| lo_i | input | 8 | Byte written to the low address bits |
| hi_latch_i | input | 8 | Latched value for address bits 15..8 |
| up_latch_i | input | 5 | Latched value for address bits 20..16 |
| pc_o | output | 21 | Byte address of the next instruction to fetch |
| sp_o | output | 5 | Number of saved return addresses |
| ovf_o | output | 1 | Sticky flag for a call made on a full stack |
| unf_o | output | 1 | Sticky flag for a return made on an empty stack |

## Verification
A call performs a stack push and a counter load in one cycle. The push may be refused because the stack is full, and the counter load must happen anyway. The bench fills the stack with 31 calls to distinct targets and then issues a 32nd call. It checks that the fetch address reaches the new target, that the pointer stays at 31 and that the overflow flag rises. It then unwinds with 31 returns, and each returned address must match the one a reference model recorded, which shows the refused push overwrote nothing. The matching case on the return side is a return on an empty stack: it must load 0 and raise the underflow flag in the same cycle.

// File: rtl/prog_ctr_pkg.sv
package prog_ctr_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_ADV   = 3'd1,
    OP_REL   = 3'd2,
    OP_JMP   = 3'd3,
    OP_CALL  = 3'd4,
    OP_RET   = 3'd5,
    OP_WRLO  = 3'd6,
    OP_SPARE = 3'd7
  } pc_op_e;
endpackage

// File: rtl/pc_next_calc.sv
module pc_next_calc
  import prog_ctr_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int REL_W = 12
) (
  input  pc_op_e            op,
  input  logic [PC_W-1:0]   pc_q,
  input  logic [REL_W-1:0]  rel,
  input  logic [PC_W-2:0]   tgt,
  input  logic [7:0]        lo,
  input  logic [7:0]        hi,
  input  logic [PC_W-17:0]  up,
  input  logic [PC_W-2:0]   pop_word,
  output logic [PC_W-1:0]   pc_d,
  output logic              pc_en
);
  localparam int EXT_W = PC_W - REL_W - 1;

  logic [PC_W-1:0] rel_bytes;
  assign rel_bytes = {{EXT_W{rel[REL_W-1]}}, rel, 1'b0};

  always_comb begin
    pc_en = 1'b1;
    pc_d  = pc_q;
    case (op)
      OP_ADV:          pc_d = pc_q + PC_W'(2);
      OP_REL:          pc_d = pc_q + rel_bytes;
      OP_JMP, OP_CALL: pc_d = {tgt, 1'b0};
      OP_RET:          pc_d = {pop_word, 1'b0};
      OP_WRLO:         pc_d = {up, hi, lo & 8'hFE};
      default:         pc_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH = 31,
  parameter int AW    = 20,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_word_i,
  output logic [AW-1:0] top_o,
  output logic [PW-1:0] sp_o,
  output logic          ovf_o,
  output logic          unf_o
);
  logic [PW-1:0] sp_q, sp_d;
  logic          ovf_q, ovf_d, unf_q, unf_d;
  logic          full, empty, wr_en, st_en;
  logic [AW-1:0] ent [DEPTH];

  assign full  = (sp_q == PW'(DEPTH));
  assign empty = (sp_q == '0);
  assign wr_en = push_i && !full;
  assign st_en = push_i || pop_i;

  always_comb begin
    sp_d  = sp_q;
    ovf_d = ovf_q;
    unf_d = unf_q;
    if (push_i) begin
      if (full) ovf_d = 1'b1;
      else      sp_d  = sp_q + PW'(1);
    end else if (pop_i) begin
      if (empty) unf_d = 1'b1;
      else       sp_d  = sp_q - PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (st_en) begin
      sp_q  <= sp_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_en && (sp_q == PW'(g))) ent[g] <= push_word_i;
    end
  end

  assign top_o = empty ? '0 : ent[sp_q - PW'(1)];
  assign sp_o  = sp_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;
endmodule

// File: rtl/prog_ctr_stack.sv
module prog_ctr_stack
  import prog_ctr_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int DEPTH = 31,
  parameter int REL_W = 12,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int UP_W = PC_W - 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_i,
  input  logic [REL_W-1:0] rel_i,
  input  logic [PC_W-2:0]  tgt_i,
  input  logic [7:0]       lo_i,
  input  logic [7:0]       hi_latch_i,
  input  logic [UP_W-1:0]  up_latch_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [PW-1:0]    sp_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic            rst_meta_q, rst_sync_n;
  pc_op_e          op;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            pc_en;
  logic [PC_W-2:0] push_word, pop_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign op        = pc_op_e'(op_i);
  assign push_word = pc_q[PC_W-1:1] + (PC_W-1)'(1);

  pc_next_calc #(.PC_W(PC_W), .REL_W(REL_W)) next_i (
    .op       (op),
    .pc_q     (pc_q),
    .rel      (rel_i),
    .tgt      (tgt_i),
    .lo       (lo_i),
    .hi       (hi_latch_i),
    .up       (up_latch_i),
    .pop_word (pop_word),
    .pc_d     (pc_d),
    .pc_en    (pc_en)
  );

  ret_stack #(.DEPTH(DEPTH), .AW(PC_W-1), .PW(PW)) stack_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .push_i      (op == OP_CALL),
    .pop_i       (op == OP_RET),
    .push_word_i (push_word),
    .top_o       (pop_word),
    .sp_o        (sp_o),
    .ovf_o       (ovf_o),
    .unf_o       (unf_o)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  pc_q <= '0;
    else if (pc_en)   pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/prog_ctr_stack_chk.sv
module prog_ctr_stack_chk
  import prog_ctr_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int DEPTH = 31,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      op_i,
  input logic [PC_W-2:0] tgt_i,
  input logic [PC_W-1:0] pc_o,
  input logic [PW-1:0]   sp_o,
  input logic            ovf_o,
  input logic            unf_o
);
  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ADV) |=> (pc_o == $past(pc_o) + PC_W'(2))); // R2
  AST_JMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_JMP) |=> (pc_o == {$past(tgt_i), 1'b0})); // R4
  AST_CALL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CALL && sp_o < PW'(DEPTH)) |=> (sp_o == $past(sp_o) + PW'(1))); // R5
  AST_RET_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_RET && sp_o != '0) |=> (sp_o == $past(sp_o) - PW'(1))); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_HOLD || op_i == OP_SPARE) |=> ($stable(pc_o) && $stable(sp_o))); // R8
  AST_NO_OVERFLOW_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CALL && sp_o == PW'(DEPTH)) |=> (sp_o == PW'(DEPTH) && ovf_o)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o); // R9
  AST_EMPTY_RET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_RET && sp_o == '0) |=> (pc_o == '0 && unf_o && sp_o == '0)); // R10
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |=> unf_o); // R10
endmodule

bind prog_ctr_stack prog_ctr_stack_chk #(.PC_W(PC_W), .DEPTH(DEPTH)) chk_i (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .op_i  (op_i),
  .tgt_i (tgt_i),
  .pc_o  (pc_o),
  .sp_o  (sp_o),
  .ovf_o (ovf_o),
  .unf_o (unf_o)
);

// File: tb/prog_ctr_stack_tb_top.sv
`timescale 1ns/1ps
module prog_ctr_stack_tb_top;
  import prog_ctr_pkg::*;

  logic        clk;
  logic        rst_n;
  logic [2:0]  op_i;
  logic [11:0] rel_i;
  logic [19:0] tgt_i;
  logic [7:0]  lo_i, hi_latch_i;
  logic [4:0]  up_latch_i;
  logic [20:0] pc_o;
  logic [4:0]  sp_o;
  logic        ovf_o, unf_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [20:0] m_pc;
  logic [20:0] m_stk [31];
  int          m_sp;
  logic        m_ovf, m_unf;

  prog_ctr_stack dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .rel_i(rel_i), .tgt_i(tgt_i),
    .lo_i(lo_i), .hi_latch_i(hi_latch_i), .up_latch_i(up_latch_i),
    .pc_o(pc_o), .sp_o(sp_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " pc"},  32'(pc_o),  32'(m_pc));
    chk({tag, " sp"},  32'(sp_o),  32'(m_sp));
    chk({tag, " ovf"}, 32'(ovf_o), 32'(m_ovf));
    chk({tag, " unf"}, 32'(unf_o), 32'(m_unf));
  endtask

  task automatic do_op(input string tag, input logic [2:0] op, input logic [11:0] rel,
                       input logic [19:0] tgt, input logic [7:0] lo,
                       input logic [7:0] hi, input logic [4:0] up);
    op_i = op; rel_i = rel; tgt_i = tgt; lo_i = lo; hi_latch_i = hi; up_latch_i = up;
    @(negedge clk);
    op_i = OP_HOLD;
    case (op)
      OP_ADV:  m_pc = m_pc + 21'd2;
      OP_REL:  m_pc = m_pc + {{8{rel[11]}}, rel, 1'b0};
      OP_JMP:  m_pc = {tgt, 1'b0};
      OP_CALL: begin
        if (m_sp == 31) m_ovf = 1'b1;
        else begin m_stk[m_sp] = m_pc + 21'd2; m_sp++; end
        m_pc = {tgt, 1'b0};
      end
      OP_RET: begin
        if (m_sp == 0) begin m_unf = 1'b1; m_pc = '0; end
        else begin m_sp--; m_pc = m_stk[m_sp]; end
      end
      OP_WRLO: m_pc = {up, hi, lo[7:1], 1'b0};
      default: ;
    endcase
    chk_all(tag);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; op_i = OP_HOLD; rel_i = '0; tgt_i = '0; lo_i = '0;
    hi_latch_i = '0; up_latch_i = '0;
    m_pc = '0; m_sp = 0; m_ovf = 1'b0; m_unf = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    apply_reset();
    chk_all("R1 reset");
  endtask

  task automatic t_advance();
    for (int i = 0; i < 3; i++) do_op("R2 advance", OP_ADV, '0, '0, '0, '0, '0);
    do_op("R4 jump top", OP_JMP, '0, 20'hFFFFF, '0, '0, '0);
    do_op("R2 wrap", OP_ADV, '0, '0, '0, '0, '0);
    chk("R2 wrap zero", 32'(pc_o), 32'h0);
  endtask

  task automatic t_relative();
    do_op("R4 jump", OP_JMP, '0, 20'h00100, '0, '0, '0);
    do_op("R3 skip four", OP_REL, 12'd4, '0, '0, '0, '0);
    chk("R3 plus eight", 32'(pc_o), 32'h208);
    do_op("R3 back three", OP_REL, 12'hFFD, '0, '0, '0, '0);
    chk("R3 minus six", 32'(pc_o), 32'h202);
    do_op("R3 wrap below zero", OP_JMP, '0, 20'h00001, '0, '0, '0);
    do_op("R3 wrap below zero", OP_REL, 12'hFFE, '0, '0, '0, '0);
    chk("R3 wrapped", 32'(pc_o), 32'h1FFFFE);
  endtask

  task automatic t_jump_wrlo();
    do_op("R4 jump", OP_JMP, '0, 20'h12345, '0, '0, '0);
    chk("R4 target", 32'(pc_o), 32'h2468A);
    do_op("R7 low write", OP_WRLO, '0, '0, 8'h57, 8'hBC, 5'h1A);
    chk("R7 merged", 32'(pc_o), 32'h1ABC56);
    do_op("R7 low even", OP_WRLO, '0, '0, 8'hE0, 8'h01, 5'h00);
    chk("R7 merged even", 32'(pc_o), 32'h0001E0);
  endtask

  task automatic t_idle();
    do_op("R8 hold", OP_HOLD, 12'h7FF, 20'hABCDE, 8'hFF, 8'hFF, 5'h1F);
    do_op("R8 spare code", OP_SPARE, 12'h7FF, 20'hABCDE, 8'hFF, 8'hFF, 5'h1F);
    chk("R8 unchanged", 32'(pc_o), 32'h0001E0);
  endtask

  task automatic t_call_ret();
    do_op("R5 call a", OP_CALL, '0, 20'h01000, '0, '0, '0);
    do_op("R5 call b", OP_CALL, '0, 20'h02000, '0, '0, '0);
    do_op("R2 advance in b", OP_ADV, '0, '0, '0, '0, '0);
    do_op("R5 call c", OP_CALL, '0, 20'h03000, '0, '0, '0);
    chk("R5 depth", 32'(sp_o), 32'd3);
    do_op("R6 ret c", OP_RET, '0, '0, '0, '0, '0);
    chk("R6 ret c addr", 32'(pc_o), 32'h4004);
    do_op("R6 ret b", OP_RET, '0, '0, '0, '0, '0);
    chk("R6 ret b addr", 32'(pc_o), 32'h2002);
    do_op("R6 ret a", OP_RET, '0, '0, '0, '0, '0);
    chk("R6 ret a addr", 32'(pc_o), 32'h1E2);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 31; i++)
      do_op("R5 fill", OP_CALL, '0, 20'(i * 24 + 7), '0, '0, '0);
    do_op("R9 full call", OP_CALL, '0, 20'h0AAAA, '0, '0, '0);
    chk("R9 target taken", 32'(pc_o), 32'h15554);
    chk("R9 flag", 32'(ovf_o), 32'd1);
    chk("R9 pointer", 32'(sp_o), 32'd31);
    for (int i = 0; i < 31; i++)
      do_op("R9 unwind intact", OP_RET, '0, '0, '0, '0, '0);
    chk("R9 flag sticky", 32'(ovf_o), 32'd1);
  endtask

  task automatic t_underflow();
    do_op("R4 jump", OP_JMP, '0, 20'h00777, '0, '0, '0);
    do_op("R10 empty ret", OP_RET, '0, '0, '0, '0, '0);
    chk("R10 pc zero", 32'(pc_o), 32'h0);
    chk("R10 flag", 32'(unf_o), 32'd1);
    do_op("R10 sticky", OP_ADV, '0, '0, '0, '0, '0);
    chk("R10 flag kept", 32'(unf_o), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_advance();
    t_relative();
    t_jump_wrlo();
    t_idle();
    t_call_ret();
    t_overflow();
    t_underflow();
    t_reset();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule